// File: doc/BRIEF.md
# Paged Program Counter with Circular Return Stack

This block holds the 13-bit instruction address of a small accumulator-style processor. On every clock edge it chooses the next address from one of five places. It can advance by one, hold, or take a new low byte from the ALU. It can also take a branch target built from a page-latch value and an 11-bit field of the instruction word, jump to a fixed interrupt vector, or restore an address saved earlier. The surrounding decode logic presents one-cycle strobes. The block turns them into the next address and, when a call or an interrupt is taken, into a save onto an internal return stack.

The return stack has eight 13-bit entries and works as a ring. Each save lands at the write pointer and moves it forward. Each restore moves it back and delivers the entry it lands on. After eight saves the next save overwrites the oldest entry. No full or empty indication is produced, and the pointer cannot be reached from outside. A restore on an empty stack wraps to the last slot and returns whatever that slot holds. For bring-up, a debug port shows the entry the next restore would deliver.

An interrupt outranks every other strobe in its cycle. The instruction strobes of that cycle are dropped, and the address they would have selected is saved so that execution resumes there.

Top module: `prog_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the PC becomes 0x0000 and the stack write pointer returns to slot 0. Stack contents are kept.
- R2: With `step_en` as the only strobe, the PC becomes PC+1 modulo 8192, so 0x1FFF goes to 0x0000. With no strobe, the PC holds.
- R3: A low-byte write makes PC[7:0] equal `alu_byte` and PC[12:8] equal `page_latch[4:0]`.
- R4: A jump or a call makes PC[10:0] equal `tgt_field` and PC[12:11] equal `page_latch[4:3]`. A call also saves the address PC+1 of the calling instruction (13-bit wrap).
- R5: A return loads the PC with the most recently saved entry that has not yet been restored.
- R6: The stack is a ring of 8 entries. The ninth save overwrites the first. After nine saves v1..v9, nine returns deliver v9, v8, ..., v2, then v9.
- R7: A return with the pointer at slot 0 (for example right after reset) delivers slot 7 and leaves the pointer at slot 7.
- R8: `irq_take` sets the PC to 0x004 regardless of other strobes. It saves the address those other strobes would have selected, and cancels their own save or restore in that cycle.
- R9: Without an interrupt, the priority order is: return, then jump or call, then low-byte write, then step.
- R10: `dbg_tos` always shows the stack entry the next return would deliver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance to the next sequential address |
| lowb_wr | input | 1 | Instruction writes the low PC byte |
| alu_byte | input | 8 | ALU result for a low-byte write |
| page_latch | input | 5 | Page-latch register value |
| jump_en | input | 1 | Jump to the instruction target |
| call_en | input | 1 | Call to the instruction target, saving the return address |
| ret_en | input | 1 | Return: restore the PC from the stack |
| irq_take | input | 1 | Vector to the interrupt address |
| tgt_field | input | 11 | Target field of the instruction word |
| pc_o | output | 13 | Current program counter (registered) |
| dbg_tos | output | 13 | Entry the next return would deliver |

## Verification
An interrupt can arrive in the same cycle as a call, a return, a jump or a plain step. Each of these collisions is provoked by raising `irq_take` together with the other strobe. The check then confirms three things: the PC lands on 0x004, `dbg_tos` holds the address the dropped strobe would have chosen, and a later return resumes exactly there. Collisions between the non-interrupt strobes (return with jump, call with low-byte write, low-byte write with step) are driven the same way and judged against the fixed priority order.

// File: rtl/prog_counter_pkg.sv
package prog_counter_pkg;

  // Source of the next program-counter value, before interrupt override
  typedef enum logic [2:0] {
    SRC_HOLD   = 3'd0,
    SRC_SEQ    = 3'd1,
    SRC_LOWB   = 3'd2,
    SRC_BRANCH = 3'd3,
    SRC_POP    = 3'd4
  } pc_src_e;

endpackage

// File: rtl/pc_src_sel.sv
module pc_src_sel
  import prog_counter_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    step_en,
  input  logic    lowb_wr,
  input  logic    jump_en,
  input  logic    call_en,
  input  logic    ret_en,
  input  logic    irq_take,
  output pc_src_e base_src,
  output logic    vec_take,
  output logic    do_push,
  output logic    do_pop
);

  // Priority among instruction strobes: return, branch, low byte, step
  always_comb begin
    if (ret_en)                  base_src = SRC_POP;
    else if (jump_en || call_en) base_src = SRC_BRANCH;
    else if (lowb_wr)            base_src = SRC_LOWB;
    else if (step_en)            base_src = SRC_SEQ;
    else                         base_src = SRC_HOLD;
  end

  assign vec_take = irq_take;

  // An interrupt replaces the instruction's own stack action with one save
  assign do_push = irq_take || (call_en && !ret_en && !irq_take);
  assign do_pop  = ret_en && !irq_take;

  // R8
  one_stack_op_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({do_push, do_pop}));

  // R8
  irq_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (do_push && !do_pop));

endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
  import prog_counter_pkg::*;
#(
  parameter int          PCW      = 13,
  parameter int          TGTW     = 11,
  parameter int          BYTEW    = 8,
  parameter int          LATW     = 5,
  parameter logic [12:0] VEC_ADDR = 13'h0004
) (
  input  pc_src_e          base_src,
  input  logic             vec_take,
  input  logic [PCW-1:0]   pc_q,
  input  logic [TGTW-1:0]  tgt_field,
  input  logic [BYTEW-1:0] alu_byte,
  input  logic [LATW-1:0]  page_latch,
  input  logic [PCW-1:0]   pop_data,
  output logic [PCW-1:0]   pc_next,
  output logic [PCW-1:0]   push_data
);

  localparam int BR_HI_W = PCW - TGTW;   // latch bits above the branch field
  localparam int LB_HI_W = PCW - BYTEW;  // latch bits above the low byte

  logic [PCW-1:0] pc_inc;
  logic [PCW-1:0] br_addr;
  logic [PCW-1:0] lowb_addr;
  logic [PCW-1:0] base_next;

  assign pc_inc    = pc_q + {{(PCW-1){1'b0}}, 1'b1};
  assign br_addr   = {page_latch[LATW-1 -: BR_HI_W], tgt_field};
  assign lowb_addr = {page_latch[LB_HI_W-1:0], alu_byte};

  always_comb begin
    unique case (base_src)
      SRC_SEQ:    base_next = pc_inc;
      SRC_LOWB:   base_next = lowb_addr;
      SRC_BRANCH: base_next = br_addr;
      SRC_POP:    base_next = pop_data;
      default:    base_next = pc_q;
    endcase
  end

  // Vector overrides; the address the instruction chose is what gets saved
  assign pc_next   = vec_take ? PCW'(VEC_ADDR) : base_next;
  assign push_data = vec_take ? base_next : pc_inc;

endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] tos
);

  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTRW-1:0] LAST = PTRW'(DEPTH - 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wr_ptr;
  logic [PTRW-1:0] rd_idx;
  logic [PTRW-1:0] ptr_up;

  assign ptr_up = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  assign rd_idx = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;

  // Pointer only; storage is left unreset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (rst)       wr_ptr <= '0;
    else if (push) wr_ptr <= ptr_up;
    else if (pop)  wr_ptr <= rd_idx;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign tos = mem[rd_idx];

  // R5
  push_then_tos_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> (tos == $past(wdata)));

  // R6
  push_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (push && wr_ptr == LAST) |=> (wr_ptr == '0));

  // R7
  pop_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && wr_ptr == '0) |=> (wr_ptr == LAST));

endmodule

// File: rtl/prog_counter.sv
module prog_counter
  import prog_counter_pkg::*;
#(
  parameter int          PCW      = 13,
  parameter int          TGTW     = 11,
  parameter int          BYTEW    = 8,
  parameter int          LATW     = 5,
  parameter int          DEPTH    = 8,
  parameter logic [12:0] VEC_ADDR = 13'h0004,
  parameter bit          DBG_VIEW = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             lowb_wr,
  input  logic [BYTEW-1:0] alu_byte,
  input  logic [LATW-1:0]  page_latch,
  input  logic             jump_en,
  input  logic             call_en,
  input  logic             ret_en,
  input  logic             irq_take,
  input  logic [TGTW-1:0]  tgt_field,
  output logic [PCW-1:0]   pc_o,
  output logic [PCW-1:0]   dbg_tos
);

  pc_src_e        base_src;
  logic           vec_take;
  logic           do_push;
  logic           do_pop;
  logic [PCW-1:0] pc_q;
  logic [PCW-1:0] pc_next;
  logic [PCW-1:0] push_data;
  logic [PCW-1:0] tos;

  pc_src_sel u_sel (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .lowb_wr  (lowb_wr),
    .jump_en  (jump_en),
    .call_en  (call_en),
    .ret_en   (ret_en),
    .irq_take (irq_take),
    .base_src (base_src),
    .vec_take (vec_take),
    .do_push  (do_push),
    .do_pop   (do_pop)
  );

  pc_next_calc #(
    .PCW      (PCW),
    .TGTW     (TGTW),
    .BYTEW    (BYTEW),
    .LATW     (LATW),
    .VEC_ADDR (VEC_ADDR)
  ) u_calc (
    .base_src   (base_src),
    .vec_take   (vec_take),
    .pc_q       (pc_q),
    .tgt_field  (tgt_field),
    .alu_byte   (alu_byte),
    .page_latch (page_latch),
    .pop_data   (tos),
    .pc_next    (pc_next),
    .push_data  (push_data)
  );

  ret_stack #(
    .DEPTH (DEPTH),
    .W     (PCW)
  ) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (do_push),
    .pop   (do_pop),
    .wdata (push_data),
    .tos   (tos)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_o = pc_q;

  generate
    if (DBG_VIEW) begin : g_dbg
      assign dbg_tos = tos;
    end else begin : g_nodbg
      assign dbg_tos = '0;
    end
  endgenerate

  // R1
  reset_pc_chk: assert property (@(posedge clk)
    rst |=> (pc_q == '0));

  // R8
  irq_vec_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> (pc_q == PCW'(VEC_ADDR)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(step_en || lowb_wr || jump_en || call_en || ret_en || irq_take)
      |=> $stable(pc_q));

  // R4
  call_save_chk: assert property (@(posedge clk) disable iff (rst)
    (call_en && !ret_en && !irq_take) |=> (tos == $past(pc_q) + 13'd1));

endmodule

// File: tb/prog_counter_test.sv
module prog_counter_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        step_en, lowb_wr, jump_en, call_en, ret_en, irq_take;
  logic [7:0]  alu_byte;
  logic [4:0]  page_latch;
  logic [10:0] tgt_field;
  logic [12:0] pc_o, dbg_tos;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  prog_counter uut (
    .clk(clk), .rst(rst), .step_en(step_en), .lowb_wr(lowb_wr),
    .alu_byte(alu_byte), .page_latch(page_latch), .jump_en(jump_en),
    .call_en(call_en), .ret_en(ret_en), .irq_take(irq_take),
    .tgt_field(tgt_field), .pc_o(pc_o), .dbg_tos(dbg_tos)
  );

  typedef struct packed {
    logic        s, lw, j, c, r, i;
    logic [10:0] tgt;
    logic [7:0]  alu;
    logic [4:0]  lat;
    logic [12:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 11'h000, 8'h00, 5'h00, 13'h0001, 4'd2}, // R2
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 11'h000, 8'h00, 5'h00, 13'h0002, 4'd2}, // R2
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 11'h000, 8'h34, 5'h05, 13'h0534, 4'd3}, // R3
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 11'h123, 8'h00, 5'h18, 13'h1923, 4'd4}, // R4
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 11'h7FF, 8'h00, 5'h08, 13'h0FFF, 4'd4}, // R4 saves 0x1924
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 11'h000, 8'h00, 5'h00, 13'h1000, 4'd2}, // R2
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 11'h000, 8'h00, 5'h00, 13'h1924, 4'd5}, // R5
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 11'h000, 8'hAA, 5'h00, 13'h00AA, 4'd9}, // R9
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 11'h010, 8'h55, 5'h00, 13'h0010, 4'd9}, // R9 saves 0x0AB
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 11'h200, 8'h00, 5'h00, 13'h00AB, 4'd9}, // R9
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 11'h000, 8'h00, 5'h00, 13'h00AC, 4'd2}, // R2
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 11'h000, 8'h00, 5'h00, 13'h0004, 4'd8}, // R8 saves 0x0AD
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 11'h000, 8'h00, 5'h00, 13'h0004, 4'd2}, // R2 hold
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 11'h000, 8'h00, 5'h00, 13'h00AD, 4'd8}  // R8 resume
  };

  task automatic chk(input string req, input logic [12:0] got, input logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic idle();
    {step_en, lowb_wr, jump_en, call_en, ret_en, irq_take} = '0;
    alu_byte = '0; page_latch = '0; tgt_field = '0;
  endtask

  // Drive strobes for one edge, then sample 2 ns after that edge
  task automatic drive(input logic s, lw, j, c, r, i,
                       input logic [10:0] t, input logic [7:0] a, input logic [4:0] l);
    step_en = s; lowb_wr = lw; jump_en = j; call_en = c; ret_en = r; irq_take = i;
    tgt_field = t; alu_byte = a; page_latch = l;
    @(posedge clk); #2;
    idle();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    @(posedge clk); #2;
    @(posedge clk); #2;
    chk("R1 reset pc", pc_o, 13'h0000);
    rst = 1'b0;

    // Vector table walk
    for (int n = 0; n < NV; n++) begin
      drive(VECS[n].s, VECS[n].lw, VECS[n].j, VECS[n].c, VECS[n].r, VECS[n].i,
            VECS[n].tgt, VECS[n].alu, VECS[n].lat);
      chk($sformatf("R%0d vector %0d", VECS[n].req, n), pc_o, VECS[n].exp);
      if (n == 4) chk("R10 tos after call", dbg_tos, 13'h1924);
    end

    // R2 wrap from top of address space
    drive(0,0,1,0,0,0, 11'h7FF, 8'h00, 5'h18);
    chk("R2 jump to top", pc_o, 13'h1FFF);
    drive(1,0,0,0,0,0, 11'h000, 8'h00, 5'h00);
    chk("R2 wrap to zero", pc_o, 13'h0000);

    // R7 and R1: fill 8 slots, reset keeps contents but clears pointer
    do_reset();
    chk("R1 reset mid-run", pc_o, 13'h0000);
    for (int k = 0; k < 8; k++) drive(0,0,0,1,0,0, 11'(11'h100 + k), 8'h00, 5'h00);
    do_reset();
    chk("R7 tos on empty", dbg_tos, 13'h0107);
    drive(0,0,0,0,1,0, 11'h000, 8'h00, 5'h00);
    chk("R7 pop on empty", pc_o, 13'h0107);

    // R6 ring: nine saves then nine restores
    do_reset();
    for (int k = 0; k < 9; k++) drive(0,0,0,1,0,0, 11'(11'h100 + k), 8'h00, 5'h00);
    for (int j = 0; j < 9; j++) begin
      logic [12:0] e;
      e = (j < 8) ? 13'(13'h108 - j) : 13'h0108;
      chk($sformatf("R10 tos before pop %0d", j), dbg_tos, e);
      drive(0,0,0,0,1,0, 11'h000, 8'h00, 5'h00);
      chk($sformatf("R6 ring pop %0d", j), pc_o, e);
    end

    // R8 interrupt colliding with a call
    do_reset();
    drive(0,0,1,0,0,0, 11'h050, 8'h00, 5'h00);
    drive(0,0,0,1,0,1, 11'h300, 8'h00, 5'h00);
    chk("R8 irq over call pc", pc_o, 13'h0004);
    chk("R8 irq saves call target", dbg_tos, 13'h0300);
    drive(0,0,0,0,1,0, 11'h000, 8'h00, 5'h00);
    chk("R8 resume at call target", pc_o, 13'h0300);

    // R8 interrupt colliding with a return: pop cancelled, popped value saved
    drive(0,0,0,1,0,0, 11'h111, 8'h00, 5'h00);  // saves 0x301
    drive(0,0,0,0,1,1, 11'h000, 8'h00, 5'h00);
    chk("R8 irq over return pc", pc_o, 13'h0004);
    drive(0,0,0,0,1,0, 11'h000, 8'h00, 5'h00);
    chk("R8 first resume", pc_o, 13'h0301);
    drive(0,0,0,0,1,0, 11'h000, 8'h00, 5'h00);
    chk("R8 cancelled pop kept entry", pc_o, 13'h0301);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule